// File: doc/BRIEF.md
# Two-phase ramp conversion sequencer

This block is the shared timing unit behind a row of column converters that digitise with ramps and one comparator per column. One start pulse runs a conversion. The conversion begins with a settling window in which the comparators auto-zero. A short coarse count follows, during which every comparator is forced onto the first ramp. A short fine count then runs while all ramps sweep together. Each column latches its coarse bits at the end of the coarse count, decodes them to pick its ramp, and latches its fine bits at the end of the fine count.

A mode input can request a plain single-ramp conversion instead. In that case the settling window is followed by one long count of full resolution on the first ramp. The block broadcasts a count bus, one flag per phase, the force-first-ramp line and end-of-phase strobes to every column slice. The analog ramps and the comparators sit outside the block.

Top module: `twoPhaseRampSeq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle. After that edge every output is 0, including `busy` and the count bus. This also holds when the reset arrives in the middle of a conversion.
- R2: `startPulse` is acted on only while `busy` is 0. While a conversion runs, including its done cycle, `startPulse` has no effect on the phase sequence or its timing.
- R3: When `startPulse` is sampled high at an idle edge, `azActive` is high for exactly AZ_CYCLES clocks, starting in the next cycle (cycles 1 to 4 after the start edge by default).
- R4: The coarse phase follows the auto-zero phase and lasts 2^COARSE_BITS clocks (cycles 5 to 12 by default). During it the count bus steps by one from 0 up to 2^COARSE_BITS-1, and `forceRamp1` is high in every one of its cycles.
- R5: `coarseEnd` is high for exactly one clock: the last coarse cycle, while the count bus holds 2^COARSE_BITS-1. The next cycle is the first fine cycle, with count 0.
- R6: The fine phase lasts 2^FINE_BITS clocks (cycles 13 to 140 by default). During it the count bus runs from 0 to 2^FINE_BITS-1 and `forceRamp1` is low. `fineEnd` is high only in the last fine cycle.
- R7: `convDone` is high for one clock, the cycle after the last count (cycle 141 by default in two-phase mode and cycle 1029 in single-ramp mode). `busy` is 0 in the cycle after that.
- R8: `singleSlopeMode` is sampled only at the accepted start edge. When it is 1, the auto-zero phase is followed by `singleActive` for 2^(COARSE_BITS+FINE_BITS) clocks, with `forceRamp1` high and the count running from 0 to 2^(COARSE_BITS+FINE_BITS)-1. `fineEnd` marks the last count, and no coarse or fine phase occurs.
- R9: At most one of `azActive`, `coarseActive`, `fineActive`, `singleActive` and `convDone` is high in any cycle. The count bus is 0 in every cycle outside the coarse, fine and single-ramp counting phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | Line-start request, taken only when idle |
| singleSlopeMode | input | 1 | 1 selects one long single-ramp count; sampled at start |
| countBus | output | BUS_W (11) | Count broadcast to all column slices |
| busy | output | 1 | High from the first auto-zero cycle through the done cycle |
| azActive | output | 1 | Auto-zero phase |
| coarseActive | output | 1 | Coarse counting phase |
| fineActive | output | 1 | Fine counting phase |
| singleActive | output | 1 | Single-ramp counting phase |
| forceRamp1 | output | 1 | Forces every comparator onto the first ramp |
| coarseEnd | output | 1 | One-clock strobe in the last coarse cycle |
| fineEnd | output | 1 | One-clock strobe in the last fine or single-ramp cycle |
| convDone | output | 1 | One-clock pulse after the final count |

## Verification
The properties assume that `startPulse` and `singleSlopeMode` are stable around each rising clock edge. They also assume that reset is held for at least one edge before any check applies. The stimulus changes every input one time unit after a rising edge and releases reset only after several reset edges. Some requests arrive while `busy` is high, and some mode changes are made mid-conversion. These are deliberate, so the properties cover a start that is ignored and a mode that has already been latched as well as the normal path.

// File: rtl/twoPhaseRampSeqPkg.sv
package twoPhaseRampSeqPkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_AZ     = 3'd1,
    PH_COARSE = 3'd2,
    PH_FINE   = 3'd3,
    PH_SINGLE = 3'd4,
    PH_DONE   = 3'd5
  } phase_t;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic clear;   // restart the count at zero on the next edge
    logic step;    // advance the count by one on the next edge
    logic show;    // drive the count onto the broadcast bus
  } cntCtrl_t;

endpackage

// File: rtl/rampSeqCount.sv
module rampSeqCount
  import twoPhaseRampSeqPkg::*;
#(
  parameter int BUS_W       = 11,
  parameter int COARSE_BITS = 3,
  parameter int FINE_BITS   = 7,
  parameter int AZ_CYCLES   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cntCtrl_t         ctl,
  output logic [BUS_W-1:0] countBus,
  output logic             atAzLast,
  output logic             atCoarseLast,
  output logic             atFineLast,
  output logic             atSingleLast
);

  localparam int FULL_BITS = COARSE_BITS + FINE_BITS;
  localparam logic [BUS_W-1:0] AZ_LAST     = BUS_W'(AZ_CYCLES - 1);
  localparam logic [BUS_W-1:0] COARSE_LAST = BUS_W'((64'd1 << COARSE_BITS) - 64'd1);
  localparam logic [BUS_W-1:0] FINE_LAST   = BUS_W'((64'd1 << FINE_BITS) - 64'd1);
  localparam logic [BUS_W-1:0] SINGLE_LAST = BUS_W'((64'd1 << FULL_BITS) - 64'd1);

  logic [BUS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) cnt <= '0;
    else if (ctl.step)    cnt <= cnt + BUS_W'(1);
  end

  always_comb begin
    atAzLast     = (cnt == AZ_LAST);
    atCoarseLast = (cnt == COARSE_LAST);
    atFineLast   = (cnt == FINE_LAST);
    atSingleLast = (cnt == SINGLE_LAST);
    countBus     = ctl.show ? cnt : '0;
  end

endmodule

// File: rtl/rampSeqCtrl.sv
module rampSeqCtrl
  import twoPhaseRampSeqPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     startPulse,
  input  logic     singleSlopeMode,
  input  logic     atAzLast,
  input  logic     atCoarseLast,
  input  logic     atFineLast,
  input  logic     atSingleLast,
  output cntCtrl_t ctl,
  output logic     busy,
  output logic     azActive,
  output logic     coarseActive,
  output logic     fineActive,
  output logic     singleActive,
  output logic     forceRamp1,
  output logic     coarseEnd,
  output logic     fineEnd,
  output logic     convDone
);

  phase_t phase, phaseNext;
  logic   modeSingle, modeSingleNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      modeSingle <= 1'b0;
    end else begin
      phase      <= phaseNext;
      modeSingle <= modeSingleNext;
    end
  end

  always_comb begin
    phaseNext      = phase;
    modeSingleNext = modeSingle;
    ctl            = '0;
    case (phase)
      PH_IDLE: begin
        if (startPulse) begin
          phaseNext      = PH_AZ;
          modeSingleNext = singleSlopeMode;
          ctl.clear      = 1'b1;
        end
      end
      PH_AZ: begin
        if (atAzLast) begin
          phaseNext = modeSingle ? PH_SINGLE : PH_COARSE;
          ctl.clear = 1'b1;
        end else begin
          ctl.step = 1'b1;
        end
      end
      PH_COARSE: begin
        ctl.show = 1'b1;
        if (atCoarseLast) begin
          phaseNext = PH_FINE;
          ctl.clear = 1'b1;
        end else begin
          ctl.step = 1'b1;
        end
      end
      PH_FINE: begin
        ctl.show = 1'b1;
        if (atFineLast) begin
          phaseNext = PH_DONE;
          ctl.clear = 1'b1;
        end else begin
          ctl.step = 1'b1;
        end
      end
      PH_SINGLE: begin
        ctl.show = 1'b1;
        if (atSingleLast) begin
          phaseNext = PH_DONE;
          ctl.clear = 1'b1;
        end else begin
          ctl.step = 1'b1;
        end
      end
      PH_DONE: begin
        phaseNext = PH_IDLE;
        ctl.clear = 1'b1;
      end
      default: begin
        phaseNext = PH_IDLE;
        ctl.clear = 1'b1;
      end
    endcase
  end

  always_comb begin
    busy         = (phase != PH_IDLE);
    azActive     = (phase == PH_AZ);
    coarseActive = (phase == PH_COARSE);
    fineActive   = (phase == PH_FINE);
    singleActive = (phase == PH_SINGLE);
    convDone     = (phase == PH_DONE);
    forceRamp1   = coarseActive || singleActive;
    coarseEnd    = coarseActive && atCoarseLast;
    fineEnd      = (fineActive && atFineLast) || (singleActive && atSingleLast);
  end

endmodule

// File: rtl/twoPhaseRampSeq.sv
module twoPhaseRampSeq
  import twoPhaseRampSeqPkg::*;
#(
  parameter int BUS_W       = 11,
  parameter int COARSE_BITS = 3,
  parameter int FINE_BITS   = 7,
  parameter int AZ_CYCLES   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startPulse,
  input  logic             singleSlopeMode,
  output logic [BUS_W-1:0] countBus,
  output logic             busy,
  output logic             azActive,
  output logic             coarseActive,
  output logic             fineActive,
  output logic             singleActive,
  output logic             forceRamp1,
  output logic             coarseEnd,
  output logic             fineEnd,
  output logic             convDone
);

  cntCtrl_t ctl;
  logic atAzLast, atCoarseLast, atFineLast, atSingleLast;

  rampSeqCtrl ctrl_i (
    .clk             (clk),
    .rst             (rst),
    .startPulse      (startPulse),
    .singleSlopeMode (singleSlopeMode),
    .atAzLast        (atAzLast),
    .atCoarseLast    (atCoarseLast),
    .atFineLast      (atFineLast),
    .atSingleLast    (atSingleLast),
    .ctl             (ctl),
    .busy            (busy),
    .azActive        (azActive),
    .coarseActive    (coarseActive),
    .fineActive      (fineActive),
    .singleActive    (singleActive),
    .forceRamp1      (forceRamp1),
    .coarseEnd       (coarseEnd),
    .fineEnd         (fineEnd),
    .convDone        (convDone)
  );

  rampSeqCount #(
    .BUS_W       (BUS_W),
    .COARSE_BITS (COARSE_BITS),
    .FINE_BITS   (FINE_BITS),
    .AZ_CYCLES   (AZ_CYCLES)
  ) count_i (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .countBus     (countBus),
    .atAzLast     (atAzLast),
    .atCoarseLast (atCoarseLast),
    .atFineLast   (atFineLast),
    .atSingleLast (atSingleLast)
  );

endmodule

// File: rtl/twoPhaseRampSeqChk.sv
module twoPhaseRampSeqChk #(
  parameter int BUS_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             startPulse,
  input logic [BUS_W-1:0] countBus,
  input logic             busy,
  input logic             azActive,
  input logic             coarseActive,
  input logic             fineActive,
  input logic             singleActive,
  input logic             forceRamp1,
  input logic             coarseEnd,
  input logic             fineEnd,
  input logic             convDone
);

  // R1: after a reset edge nothing is active
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> !busy && countBus == '0 && !convDone);

  // R2: a running conversion is not disturbed
  a_r2_keep_running: assert property (@(posedge clk) disable iff (rst)
    (busy && !convDone) |=> busy);

  // R3: an accepted start enters auto-zero
  a_r3_start_to_az: assert property (@(posedge clk) disable iff (rst)
    (!busy && startPulse) |=> azActive);

  // R4: coarse count steps by one, first ramp forced
  a_r4_coarse_step: assert property (@(posedge clk) disable iff (rst)
    (coarseActive && $past(coarseActive)) |-> countBus == BUS_W'($past(countBus) + 1));

  a_r4_coarse_forced: assert property (@(posedge clk) disable iff (rst)
    coarseActive |-> forceRamp1);

  // R5: coarse end hands over to fine at count zero
  a_r5_coarse_to_fine: assert property (@(posedge clk) disable iff (rst)
    coarseEnd |=> fineActive && countBus == '0);

  // R6: fine phase never forces the first ramp
  a_r6_fine_free: assert property (@(posedge clk) disable iff (rst)
    fineActive |-> !forceRamp1);

  // R7: final strobe then done then idle
  a_r7_end_done: assert property (@(posedge clk) disable iff (rst)
    fineEnd |=> convDone);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    convDone |=> !busy);

  // R8: single-ramp count forces ramp one and has no coarse strobe
  a_r8_single_forced: assert property (@(posedge clk) disable iff (rst)
    singleActive |-> forceRamp1 && !coarseEnd);

  // R9: phases exclusive, bus idle outside counting
  a_r9_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({azActive, coarseActive, fineActive, singleActive, convDone}));

  a_r9_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    !(coarseActive || fineActive || singleActive) |-> countBus == '0);

endmodule

bind twoPhaseRampSeq twoPhaseRampSeqChk #(.BUS_W(BUS_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .startPulse   (startPulse),
  .countBus     (countBus),
  .busy         (busy),
  .azActive     (azActive),
  .coarseActive (coarseActive),
  .fineActive   (fineActive),
  .singleActive (singleActive),
  .forceRamp1   (forceRamp1),
  .coarseEnd    (coarseEnd),
  .fineEnd      (fineEnd),
  .convDone     (convDone)
);

// File: tb/twoPhaseRampSeq_tb_top.sv
`timescale 1ns/1ps
module twoPhaseRampSeq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startPulse = 1'b0;
  logic        modeSel = 1'b0;
  logic [10:0] countBus;
  logic busy, azActive, coarseActive, fineActive, singleActive;
  logic forceRamp1, coarseEnd, fineEnd, convDone;

  int checkCount = 0;
  int failCount  = 0;
  int curT       = 0;
  bit finished   = 1'b0;

  always #10 clk = ~clk;

  twoPhaseRampSeq dut_i (
    .clk             (clk),
    .rst             (rst),
    .startPulse      (startPulse),
    .singleSlopeMode (modeSel),
    .countBus        (countBus),
    .busy            (busy),
    .azActive        (azActive),
    .coarseActive    (coarseActive),
    .fineActive      (fineActive),
    .singleActive    (singleActive),
    .forceRamp1      (forceRamp1),
    .coarseEnd       (coarseEnd),
    .fineEnd         (fineEnd),
    .convDone        (convDone)
  );

  // flag order: busy az coarse fine single force cEnd fEnd done
  localparam logic [8:0] F_IDLE  = 9'b000000000;
  localparam logic [8:0] F_AZ    = 9'b110000000;
  localparam logic [8:0] F_CRS   = 9'b101001000;
  localparam logic [8:0] F_CRSL  = 9'b101001100;
  localparam logic [8:0] F_FIN   = 9'b100100000;
  localparam logic [8:0] F_FINL  = 9'b100100010;
  localparam logic [8:0] F_DONE  = 9'b100000001;
  localparam logic [8:0] F_SGL   = 9'b100011000;
  localparam logic [8:0] F_SGLL  = 9'b100011010;

  // entry: {req[3:0], mode, t[10:0], flags[8:0], count[10:0]}
  localparam int NVEC = 16;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd3, 1'b0, 11'd1,    F_AZ,   11'd0},    // R3 first auto-zero cycle
    {4'd9, 1'b0, 11'd4,    F_AZ,   11'd0},    // R9 bus quiet in auto-zero
    {4'd4, 1'b0, 11'd5,    F_CRS,  11'd0},    // R4 coarse begins
    {4'd4, 1'b0, 11'd9,    F_CRS,  11'd4},    // R4 coarse mid
    {4'd5, 1'b0, 11'd12,   F_CRSL, 11'd7},    // R5 coarse end strobe
    {4'd6, 1'b0, 11'd13,   F_FIN,  11'd0},    // R6 fine begins
    {4'd6, 1'b0, 11'd77,   F_FIN,  11'd64},   // R6 fine mid
    {4'd6, 1'b0, 11'd140,  F_FINL, 11'd127},  // R6 fine end strobe
    {4'd7, 1'b0, 11'd141,  F_DONE, 11'd0},    // R7 done pulse
    {4'd7, 1'b0, 11'd142,  F_IDLE, 11'd0},    // R7 back to idle
    {4'd3, 1'b1, 11'd4,    F_AZ,   11'd0},    // R3 auto-zero in single mode
    {4'd8, 1'b1, 11'd5,    F_SGL,  11'd0},    // R8 single count begins
    {4'd8, 1'b1, 11'd700,  F_SGL,  11'd695},  // R8 single mid
    {4'd8, 1'b1, 11'd1028, F_SGLL, 11'd1023}, // R8 single last count
    {4'd7, 1'b1, 11'd1029, F_DONE, 11'd0},    // R7 done after single
    {4'd7, 1'b1, 11'd1030, F_IDLE, 11'd0}     // R7 idle after single
  };

  function automatic logic [8:0] flagsNow();
    return {busy, azActive, coarseActive, fineActive, singleActive,
            forceRamp1, coarseEnd, fineEnd, convDone};
  endfunction

  task automatic check(input string tag, input logic [8:0] expF, input logic [10:0] expC);
    checkCount++;
    if (flagsNow() !== expF || countBus !== expC) begin
      failCount++;
      $display("FAIL %s t=%0d flags=%b count=%0d expected flags=%b count=%0d",
               tag, curT, flagsNow(), countBus, expF, expC);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    curT++;
  endtask

  task automatic beginConv(input logic m);
    startPulse = 1'b1;
    modeSel    = m;
    curT       = 0;
    tick();
    startPulse = 1'b0;
  endtask

  task automatic stepTo(input int n);
    while (curT < n) tick();
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && busy; k++) tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", F_IDLE, 11'd0);
    rst = 1'b0;
    tick();

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      beginConv(VEC[i][31]);
      stepTo(int'(VEC[i][30:20]));
      check($sformatf("R%0d vector %0d", VEC[i][35:32], i), VEC[i][19:11], VEC[i][10:0]);
      drain();
    end

    // R4 full coarse sweep
    beginConv(1'b0);
    for (int t = 5; t <= 12; t++) begin
      stepTo(t);
      check("R4 coarse sweep", (t == 12) ? F_CRSL : F_CRS, 11'(t - 5));
    end
    drain();

    // R2 start while busy is ignored; R8 mode change mid-run ignored
    beginConv(1'b0);
    stepTo(2);
    modeSel = 1'b1;
    stepTo(20);
    startPulse = 1'b1;
    tick();
    startPulse = 1'b0;
    stepTo(5 + 0);
    stepTo(140);
    check("R2 busy start ignored, fine end", F_FINL, 11'd127);
    stepTo(141);
    check("R2 busy start ignored, done", F_DONE, 11'd0);
    // R2 start during the done cycle is ignored
    startPulse = 1'b1;
    tick();
    startPulse = 1'b0;
    check("R2 start in done cycle ignored", F_IDLE, 11'd0);
    tick();
    check("R2 still idle", F_IDLE, 11'd0);
    modeSel = 1'b0;

    // R8 latched mode: set single, clear mode in auto-zero
    beginConv(1'b1);
    modeSel = 1'b0;
    stepTo(5);
    check("R8 mode latched at start", F_SGL, 11'd0);
    // R1 reset mid-conversion
    rst = 1'b1;
    tick();
    check("R1 reset mid-run", F_IDLE, 11'd0);
    rst = 1'b0;
    tick();
    check("R1 stays idle after reset", F_IDLE, 11'd0);

    // R3 back-to-back: start in first idle cycle after done
    beginConv(1'b0);
    stepTo(142);
    beginConv(1'b0);
    check("R3 back-to-back start", F_AZ, 11'd0);
    drain();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule